// File: doc/BRIEF.md
# Task Queue Load Balancer

This block holds one small first-in first-out queue of task records for each processing core. It watches how many tasks each queue holds and moves work from the busiest queue to the idlest one. A task record is a compact word: a codelet index in the upper bits and an argument chunk handle in the lower bits. Each core's local scheduler adds tasks through a push port and takes them through a show-ahead pop port. A central controller compares the live queue counts every cycle. When the spread between the fullest and the emptiest queue is large enough, it tells the source queue to give up its oldest record. That record travels over one shared transfer register and lands at the tail of the destination queue.

Only one migration is in flight at a time. A transfer takes one decision cycle, one fetch cycle and at least one delivery cycle. The core-facing ports always take priority over the transfer path. If a core pops its own queue in the cycle the balancer wants to fetch from it, the migration is abandoned, and the decision is made again later from fresh counts. The queue counts, a busy flag and a running count of completed migrations are exported as status.

Top module: `lb_task_balancer`

## Requirements
- R1: Each core queue holds up to DEPTH records and keeps them in arrival order. `push_ready[i]` is high exactly when queue i is not full. A push while the queue is full is ignored, and its count stays at DEPTH.
- R2: `pop_valid[i]` is high when queue i is non-empty, and `pop_data` slice i shows its oldest record. A pop request on an empty queue is ignored.
- R3: A migration starts only when (largest count − smallest count) ≥ T_eff. T_eff is the `thresh` input, except that values 0 and 1 count as 2. Balancing therefore stops once the spread falls below T_eff.
- R4: The source is the lowest-indexed queue among those holding the largest count. The destination is the lowest-indexed queue among those holding the smallest count. The oldest record of the source is appended to the tail of the destination.
- R5: At most one migration is in flight. `xfer_busy` rises after the decision edge. The source count drops by one at the next edge. If the destination accepts at the following edge, its count rises by one and `xfer_busy` falls there.
- R6: If the core raises `pop_req` on the source queue during the fetch cycle, the core's pop is served, the migration is cancelled with no record moved, and the controller returns to deciding.
- R7: During delivery, a core push to the destination, or a full destination, makes the transfer wait. The core's record enters first, and the migrated record follows on a later cycle.
- R8: `migrate_count` increases by exactly one for every record delivered, and changes at no other time.
- R9: After reset is asserted (active low), all queues are empty, `push_ready` is all ones, `pop_valid` is all zeros, `xfer_busy` is 0 and `migrate_count` is 0.
- R10: No record is lost or duplicated. Queued records plus the one in flight change only through core pushes and pops that are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thresh | input | CNT_W | Migration spread threshold (0 and 1 act as 2) |
| push_valid | input | N_CORES | Per-core push strobe |
| push_data | input | N_CORES*REC_W | Per-core record to push, {codelet index, handle} |
| push_ready | output | N_CORES | Queue not full |
| pop_req | input | N_CORES | Per-core pop strobe |
| pop_data | output | N_CORES*REC_W | Oldest record of each queue |
| pop_valid | output | N_CORES | Queue not empty |
| occupancy | output | N_CORES*CNT_W | Record count of each queue |
| xfer_busy | output | 1 | A migration is in progress |
| migrate_count | output | MIG_W | Completed migrations, wraps |

## Verification
Several properties are checked on every cycle: queue counts stay within bound, records are conserved across the transfer path, no migration starts while the spread is below the effective threshold, a fetch-cycle pop by the source core cancels the move, and the migration count moves only on delivery. Other behaviours can only be shown by the bench's scenarios. These include tie-breaking by lowest index, the final balanced distribution for each starting load, the oldest-record-first order of what is moved, the exact cycle timing of a transfer, and a core push overtaking a pending delivery.

// File: rtl/lb_pkg.sv
// Shared definitions for the task queue load balancer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lb_pkg;

    // Controller phases: choose a pair, pull from source, push to destination.
    typedef enum logic [1:0] {
        LB_IDLE    = 2'd0,
        LB_FETCH   = 2'd1,
        LB_DELIVER = 2'd2
    } lb_state_e;

    // Smallest spread that may ever trigger a migration (avoids ping-pong).
    localparam int LB_MIN_SPREAD = 2;

endpackage

// File: rtl/lb_task_fifo.sv
// One core's local task queue: a circular buffer with show-ahead read.
// Assumes DEPTH >= 2. Writes when full and reads when empty are dropped here
// as a second line of defence; the top already gates them.
module lb_task_fifo #(
    parameter int DEPTH = 8,
    parameter int REC_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REC_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [REC_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             wr_fire;
    logic             rd_fire;

    // Qualify the requests against the current fill state.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        wr_fire = wr_en && !full;
        rd_fire = rd_en && !empty;
        rd_data = mem[rd_ptr];
    end

    // Store the incoming record at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers and track the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_fire) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_fire) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({wr_fire, rd_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lb_select.sv
// Finds the fullest and emptiest queues from a flat vector of counts.
// Ties go to the lowest index because the scan only replaces on strict compare.
// Purely combinational; the depth grows linearly with N_CORES.
module lb_select #(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 4,
    localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic [N_CORES*CNT_W-1:0] counts,
    output logic [SEL_W-1:0]         max_idx,
    output logic [SEL_W-1:0]         min_idx,
    output logic [CNT_W-1:0]         max_val,
    output logic [CNT_W-1:0]         min_val
);

    // Linear scan from core 0 upward, keeping the first extreme seen.
    always_comb begin
        max_idx = '0;
        min_idx = '0;
        max_val = counts[CNT_W-1:0];
        min_val = counts[CNT_W-1:0];
        for (int i = 1; i < N_CORES; i++) begin
            if (counts[i*CNT_W +: CNT_W] > max_val) begin
                max_val = counts[i*CNT_W +: CNT_W];
                max_idx = SEL_W'(i);
            end
            if (counts[i*CNT_W +: CNT_W] < min_val) begin
                min_val = counts[i*CNT_W +: CNT_W];
                min_idx = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/lb_ctrl.sv
// Migration controller: decides, fetches the source head into a holding
// register, then delivers it to the destination when the port is free.
// Assumes the top suppresses core-side conflicts reported on its inputs.
module lb_ctrl
    import lb_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 4,
    parameter int REC_W   = 32,
    parameter int MIG_W   = 16,
    localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] thresh,
    input  logic [SEL_W-1:0] max_idx,
    input  logic [SEL_W-1:0] min_idx,
    input  logic [CNT_W-1:0] max_val,
    input  logic [CNT_W-1:0] min_val,
    input  logic             src_core_pop,
    input  logic             src_empty,
    input  logic [REC_W-1:0] src_head,
    input  logic             dst_full,
    input  logic             dst_core_push,
    output lb_state_e        state,
    output logic [SEL_W-1:0] src_idx,
    output logic [SEL_W-1:0] dst_idx,
    output logic             fetch_fire,
    output logic             deliver_fire,
    output logic [REC_W-1:0] held_rec,
    output logic [MIG_W-1:0] migrate_count
);

    logic [CNT_W-1:0] eff_thresh;
    logic [CNT_W-1:0] spread;
    logic             want_move;

    // Apply the floor on the threshold and evaluate the spread.
    always_comb begin
        eff_thresh = (thresh < CNT_W'(LB_MIN_SPREAD)) ? CNT_W'(LB_MIN_SPREAD) : thresh;
        spread     = max_val - min_val;
        want_move  = (spread >= eff_thresh) && (max_idx != min_idx);
    end

    // Strobes for the queue ports in the fetch and deliver phases.
    always_comb begin
        fetch_fire   = (state == LB_FETCH) && !src_core_pop && !src_empty;
        deliver_fire = (state == LB_DELIVER) && !dst_full && !dst_core_push;
    end

    // Phase sequencing, pair latching, record holding and the migration tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= LB_IDLE;
            src_idx       <= '0;
            dst_idx       <= '0;
            held_rec      <= '0;
            migrate_count <= '0;
        end else begin
            case (state)
                LB_IDLE: begin
                    if (want_move) begin
                        src_idx <= max_idx;
                        dst_idx <= min_idx;
                        state   <= LB_FETCH;
                    end
                end
                LB_FETCH: begin
                    if (fetch_fire) begin
                        held_rec <= src_head;
                        state    <= LB_DELIVER;
                    end else begin
                        state    <= LB_IDLE;
                    end
                end
                LB_DELIVER: begin
                    if (deliver_fire) begin
                        migrate_count <= migrate_count + 1'b1;
                        state         <= LB_IDLE;
                    end
                end
                default: state <= LB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lb_task_balancer.sv
// Top of the task queue load balancer: one queue per core, a min/max
// selector over live counts, and a single-slot migration controller.
// Core push/pop ports always win over the transfer path. Records are
// {codelet index, argument handle}, codelet index in the upper IDX_W bits.
module lb_task_balancer
    import lb_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int DEPTH    = 8,
    parameter int IDX_W    = 8,
    parameter int HANDLE_W = 24,
    parameter int MIG_W    = 16,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int REC_W   = IDX_W + HANDLE_W,
    localparam int SEL_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         thresh,
    input  logic [N_CORES-1:0]       push_valid,
    input  logic [N_CORES*REC_W-1:0] push_data,
    output logic [N_CORES-1:0]       push_ready,
    input  logic [N_CORES-1:0]       pop_req,
    output logic [N_CORES*REC_W-1:0] pop_data,
    output logic [N_CORES-1:0]       pop_valid,
    output logic [N_CORES*CNT_W-1:0] occupancy,
    output logic                     xfer_busy,
    output logic [MIG_W-1:0]         migrate_count
);

    lb_state_e          state;
    logic [SEL_W-1:0]   src_idx;
    logic [SEL_W-1:0]   dst_idx;
    logic [SEL_W-1:0]   max_idx;
    logic [SEL_W-1:0]   min_idx;
    logic [CNT_W-1:0]   max_val;
    logic [CNT_W-1:0]   min_val;
    logic               fetch_fire;
    logic               deliver_fire;
    logic [REC_W-1:0]   held_rec;
    logic [N_CORES-1:0] q_full;
    logic [N_CORES-1:0] q_empty;
    logic [N_CORES-1:0] core_push;
    logic [N_CORES-1:0] core_pop;
    logic [REC_W-1:0]   q_head [N_CORES];

    // Per-core queues with their port arbitration.
    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        logic             wr_en;
        logic [REC_W-1:0] wr_data;
        logic             rd_en;

        // Core traffic first; the transfer path only fills idle port slots.
        always_comb begin
            core_push[g] = push_valid[g] && !q_full[g];
            core_pop[g]  = pop_req[g] && !q_empty[g];
            wr_en        = core_push[g] || (deliver_fire && (dst_idx == SEL_W'(g)));
            wr_data      = core_push[g] ? push_data[g*REC_W +: REC_W] : held_rec;
            rd_en        = core_pop[g] || (fetch_fire && (src_idx == SEL_W'(g)));
        end

        lb_task_fifo #(
            .DEPTH (DEPTH),
            .REC_W (REC_W)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .rd_en   (rd_en),
            .rd_data (q_head[g]),
            .count   (occupancy[g*CNT_W +: CNT_W]),
            .full    (q_full[g]),
            .empty   (q_empty[g])
        );

        // Expose the queue state on the core-facing ports.
        always_comb begin
            push_ready[g]               = !q_full[g];
            pop_valid[g]                = !q_empty[g];
            pop_data[g*REC_W +: REC_W]  = q_head[g];
        end
    end

    lb_select #(
        .N_CORES (N_CORES),
        .CNT_W   (CNT_W)
    ) u_select (
        .counts  (occupancy),
        .max_idx (max_idx),
        .min_idx (min_idx),
        .max_val (max_val),
        .min_val (min_val)
    );

    lb_ctrl #(
        .N_CORES (N_CORES),
        .CNT_W   (CNT_W),
        .REC_W   (REC_W),
        .MIG_W   (MIG_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .thresh        (thresh),
        .max_idx       (max_idx),
        .min_idx       (min_idx),
        .max_val       (max_val),
        .min_val       (min_val),
        .src_core_pop  (pop_req[src_idx]),
        .src_empty     (q_empty[src_idx]),
        .src_head      (q_head[src_idx]),
        .dst_full      (q_full[dst_idx]),
        .dst_core_push (push_valid[dst_idx]),
        .state         (state),
        .src_idx       (src_idx),
        .dst_idx       (dst_idx),
        .fetch_fire    (fetch_fire),
        .deliver_fire  (deliver_fire),
        .held_rec      (held_rec),
        .migrate_count (migrate_count)
    );

    // Busy whenever the controller is past the decision phase.
    always_comb begin
        xfer_busy = (state != LB_IDLE);
    end

endmodule

// File: rtl/lb_task_balancer_chk.sv
// Cycle-by-cycle properties of the load balancer, bound into the top.
// Assumes the synchronous active-low reset is asserted from time zero.
module lb_task_balancer_chk
    import lb_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 4,
    parameter int MIG_W   = 16,
    localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CNT_W-1:0]         thresh,
    input logic [N_CORES-1:0]       push_valid,
    input logic [N_CORES-1:0]       push_ready,
    input logic [N_CORES-1:0]       pop_req,
    input logic [N_CORES-1:0]       pop_valid,
    input logic [N_CORES*CNT_W-1:0] occupancy,
    input logic [MIG_W-1:0]         migrate_count,
    input lb_state_e                state,
    input logic [SEL_W-1:0]         src_idx
);

    int total;
    int pushes;
    int pops;
    int hi;
    int lo;
    int eff;

    // Independent tally of held records, accepted traffic and the spread.
    always_comb begin
        total  = (state == LB_DELIVER) ? 1 : 0;
        hi     = 0;
        lo     = DEPTH;
        for (int i = 0; i < N_CORES; i++) begin
            total += int'(occupancy[i*CNT_W +: CNT_W]);
            if (int'(occupancy[i*CNT_W +: CNT_W]) > hi) hi = int'(occupancy[i*CNT_W +: CNT_W]);
            if (int'(occupancy[i*CNT_W +: CNT_W]) < lo) lo = int'(occupancy[i*CNT_W +: CNT_W]);
        end
        pushes = $countones(push_valid & push_ready);
        pops   = $countones(pop_req & pop_valid);
        eff    = (int'(thresh) < LB_MIN_SPREAD) ? LB_MIN_SPREAD : int'(thresh);
    end

    for (genvar g = 0; g < N_CORES; g++) begin : g_bound
        assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
            int'(occupancy[g*CNT_W +: CNT_W]) <= DEPTH);
    end

    assert_no_early_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LB_IDLE) && ((hi - lo) < eff) |=> (state == LB_IDLE));

    assert_cancel_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LB_FETCH) && pop_req[src_idx] |=> (state == LB_IDLE) && $stable(migrate_count));

    assert_count_on_deliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LB_DELIVER) |=> $stable(migrate_count));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (migrate_count == $past(migrate_count)) ||
                 (migrate_count == $past(migrate_count) + MIG_W'(1)));

    assert_conserve_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> total == $past(total) + $past(pushes) - $past(pops));

endmodule

bind lb_task_balancer lb_task_balancer_chk #(
    .N_CORES (N_CORES),
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .MIG_W   (MIG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thresh        (thresh),
    .push_valid    (push_valid),
    .push_ready    (push_ready),
    .pop_req       (pop_req),
    .pop_valid     (pop_valid),
    .occupancy     (occupancy),
    .migrate_count (migrate_count),
    .state         (state),
    .src_idx       (src_idx)
);

// File: tb/tb_lb_task_balancer.sv
// Self-checking bench: a table of starting loads walked by one loop, then
// directed tests for reset, timing, cancellation, priority and limits.
module tb_lb_task_balancer;

    localparam int CLK_PERIOD = 10;
    localparam int NC    = 4;
    localparam int DEP   = 8;
    localparam int CW    = 4;
    localparam int RW    = 32;
    localparam int MW    = 16;
    localparam int NVEC  = 7;

    // Starting counts, threshold, expected final counts and migrations.
    localparam int V_INIT [NVEC][NC] = '{'{4,0,0,0}, '{0,0,0,6}, '{5,5,0,0},
        '{2,3,2,3}, '{8,0,0,0}, '{0,7,0,7}, '{3,0,0,0}};
    localparam int V_TH [NVEC] = '{2, 2, 3, 2, 4, 2, 0};
    localparam int V_FIN [NVEC][NC] = '{'{1,1,1,1}, '{2,1,1,2}, '{3,3,2,2},
        '{2,3,2,3}, '{4,2,1,1}, '{3,4,3,4}, '{1,1,1,0}};
    localparam int V_MOV [NVEC] = '{3, 4, 4, 0, 4, 6, 2};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     thresh = '1;
    logic [NC-1:0]     push_valid = '0;
    logic [NC*RW-1:0]  push_data = '0;
    logic [NC-1:0]     push_ready;
    logic [NC-1:0]     pop_req = '0;
    logic [NC*RW-1:0]  pop_data;
    logic [NC-1:0]     pop_valid;
    logic [NC*CW-1:0]  occupancy;
    logic              xfer_busy;
    logic [MW-1:0]     migrate_count;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    lb_task_balancer #(.N_CORES(NC), .DEPTH(DEP), .IDX_W(8), .HANDLE_W(24), .MIG_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .occupancy(occupancy), .xfer_busy(xfer_busy), .migrate_count(migrate_count));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record layout: codelet index in bits 31:24, handle in bits 23:0.
    function automatic int mkrec(int core, int seq);
        return ((core * 16 + seq) << 24) | 32'h00A000 | (core << 8) | seq;
    endfunction

    function automatic int occ(int c);
        return int'(occupancy[c*CW +: CW]);
    endfunction

    function automatic int head(int c);
        return int'(pop_data[c*RW +: RW]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge.
    task automatic push_rec(input int c, input int rec);
        push_valid[c] = 1'b1;
        push_data[c*RW +: RW] = rec;
        @(negedge clk);
        push_valid[c] = 1'b0;
    endtask

    task automatic pop_one(input int c);
        pop_req[c] = 1'b1;
        @(negedge clk);
        pop_req[c] = 1'b0;
    endtask

    task automatic quiesce_and_drain();
        thresh = '1;
        @(negedge clk);
        while (xfer_busy) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            while (pop_valid[c]) pop_one(c);
        end
    endtask

    task automatic load(input int c, input int n);
        for (int k = 0; k < n; k++) push_rec(c, mkrec(c, k));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state.
        chk("R9 occupancy", int'(occupancy), 0);
        chk("R9 push_ready", int'(push_ready), 15);
        chk("R9 pop_valid", int'(pop_valid), 0);
        chk("R9 busy", int'(xfer_busy), 0);
        chk("R9 migrate_count", int'(migrate_count), 0);

        // R3 R4 R8: table of starting loads walked to a balanced state.
        for (int v = 0; v < NVEC; v++) begin
            quiesce_and_drain();
            for (int c = 0; c < NC; c++) load(c, V_INIT[v][c]);
            base = int'(migrate_count);
            thresh = CW'(V_TH[v]);
            repeat (200) @(negedge clk);
            for (int c = 0; c < NC; c++) chk($sformatf("R3 R4 vec%0d core%0d", v, c), occ(c), V_FIN[v][c]);
            chk($sformatf("R8 vec%0d moves", v), int'(migrate_count) - base, V_MOV[v]);
            if (v == 0) begin
                // R4 R10: oldest records moved in order, lowest-index destinations first.
                chk("R4 core1 head", head(1), mkrec(0, 0));
                chk("R4 core2 head", head(2), mkrec(0, 1));
                chk("R4 core3 head", head(3), mkrec(0, 2));
                chk("R4 core0 head", head(0), mkrec(0, 3));
            end
        end

        // R5: cycle timing of one migration.
        quiesce_and_drain();
        load(0, 2);
        base = int'(migrate_count);
        thresh = 2;
        @(negedge clk);
        chk("R5 busy after decision", int'(xfer_busy), 1);
        chk("R5 src before fetch", occ(0), 2);
        @(negedge clk);
        chk("R5 src after fetch", occ(0), 1);
        chk("R5 dst before deliver", occ(1), 0);
        @(negedge clk);
        chk("R5 dst after deliver", occ(1), 1);
        chk("R5 busy after deliver", int'(xfer_busy), 0);
        chk("R8 single move", int'(migrate_count) - base, 1);
        chk("R10 moved record", head(1), mkrec(0, 0));

        // R6: source core pops in the fetch cycle, so the move is cancelled.
        quiesce_and_drain();
        load(0, 2);
        base = int'(migrate_count);
        thresh = 2;
        pop_req[0] = 1'b1;
        chk("R6 first popped", head(0), mkrec(0, 0));
        @(negedge clk);
        chk("R6 busy in fetch", int'(xfer_busy), 1);
        chk("R6 second popped", head(0), mkrec(0, 1));
        @(negedge clk);
        pop_req[0] = 1'b0;
        chk("R6 busy cleared", int'(xfer_busy), 0);
        chk("R6 all empty", int'(occupancy), 0);
        chk("R6 no move counted", int'(migrate_count) - base, 0);
        repeat (5) @(negedge clk);
        chk("R6 still empty", int'(occupancy), 0);

        // R7: core push to destination overtakes the pending delivery.
        quiesce_and_drain();
        load(0, 2);
        base = int'(migrate_count);
        thresh = 2;
        repeat (2) @(negedge clk);
        push_rec(1, 32'h7700BEEF);
        chk("R7 core push first", occ(1), 1);
        chk("R7 still busy", int'(xfer_busy), 1);
        chk("R7 no move yet", int'(migrate_count) - base, 0);
        @(negedge clk);
        chk("R7 delivered after", occ(1), 2);
        chk("R7 busy cleared", int'(xfer_busy), 0);
        chk("R7 head is core record", head(1), 32'h7700BEEF);
        pop_one(1);
        chk("R7 migrated follows", head(1), mkrec(0, 0));

        // R1: full queue ignores pushes and keeps order.
        quiesce_and_drain();
        load(2, 8);
        chk("R1 full not ready", int'(push_ready[2]), 0);
        push_rec(2, 32'h11111111);
        chk("R1 count capped", occ(2), 8);
        chk("R1 order kept", head(2), mkrec(2, 0));
        pop_one(2);
        chk("R1 second in order", head(2), mkrec(2, 1));

        // R2: pop on an empty queue is ignored.
        pop_one(3);
        chk("R2 empty stays empty", occ(3), 0);
        chk("R2 empty not valid", int'(pop_valid[3]), 0);
        chk("R2 other unaffected", occ(2), 7);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule